// File: doc/BRIEF.md
# Serial block check unit

This peripheral computes a block check character over bytes or 16-bit words that a processor writes to it. It has three word registers on a small register bus: a control and status word, a read-only block check word, and a write-only data word. One serial engine covers five codes, selected by a 3-bit code field: CRC-12, CRC-16, CRC-CCITT, an 8-bit longitudinal check and a 16-bit longitudinal check. A separate flag doubles the number of bits that each operation consumes.

With the run flag set, writing the data word starts the engine. It then consumes one data bit per clock, least significant first, until the bit count for the selected code has been processed. With the run flag clear, software advances the engine one bit at a time by writing a step command to the status word. A status bit shows the feedback bit of the most recent shift. In CRC-12 the upper six bits of the check value are kept at a shifted position inside the register. Only one unit is built.

Top module: `blockcheck_unit`

## Requirements
- R1: After a synchronous active-high reset, the status word reads 0x0080 (only the done flag set) and the check word reads 0x0000.
- R2: bus_addr[2:1] selects the word: 0 is status, 1 is check, 2 and 3 are data. A read request registers its result into bus_rdata at the next clock edge. Data-word reads return 0. The status word reads as bit 8 quotient, bit 7 done, bit 6 run, bit 3 double, bits 2:0 code, and all other bits 0.
- R3: A write to the check word leaves the check value unchanged.
- R4: The code field selects the operation: 0 is CRC-12 (polynomial 0x0F01, 6 bits per operation), 1 is CRC-16 (0xA001, 8 bits), 2 is LRC-8 (8 bits), 3 is LRC-16 (8 bits) and 5 is CRC-CCITT (0x8408, 8 bits). The double flag (status bit 3) doubles each count. Codes 4, 6 and 7 have a count of zero and finish after a single bit cycle.
- R5: One bit cycle does the following. q = check[0] XOR data[0], and q is written into check[0]. If code bit 1 is set, the check value is rotated right by one: over 16 bits when code bit 0 is set, otherwise over the low 8 bits with the high byte cleared. If code bit 1 is clear, the check value is shifted right by one and XORed with the polynomial when q is 1. The data word shifts right by one, and the quotient flag takes q.
- R6: In CRC-12, bits 13:8 of the check value move down to 11:6 before each cycle and back up afterwards. Bits 5:0 are not moved, and bits 15:14 and 7:6 end up zero.
- R7: A data-word write clears done and zeroes the bit counter. If the run flag is set, the engine then does one bit cycle on each of the following clocks. Done rises on the clock of the last required cycle, and the counter returns to zero at that point.
- R8: A status write with the step flag (bit 5) set and the run flag (bit 6) clear performs exactly one bit cycle under the newly written setting. With the run flag set it performs none. No cycle ever happens while done is set.
- R9: A status write with the clear flag (bit 4) set zeroes the check value and the counter and sets done. The quotient flag keeps its value.
- R10: A status write that changes bits 3:0 resets the bit counter, so the next operation needs its full count of steps.
- R11: When bus_byte is set, the byte is taken from bus_wdata[7:0]. A data-word byte write at an odd address replaces the high byte, and at an even address it replaces the low byte. A status byte write at an even address acts as a full status write. At an odd address it is ignored.
- R12: A data-word write during an automatic run restarts the run on the new data. The check value built so far is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_byte | input | 1 | Byte access (data in bus_wdata[7:0]) |
| bus_addr | input | 3 | Byte address within the unit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench runs every code, in both single and double length, over several data words and compares the result with a bit-level model of the shift rule. A wrong polynomial, rotation width or CRC-12 bit placement would therefore show up as a wrong check word. It checks the exact clock on which done rises after a data write, and it checks that an undefined code takes exactly one cycle. An engine that miscounts, or that starts a clock late, would give the wrong done value on the clock sampled. The stepping tests cover four cases: a step issued while the run flag is set, a step issued after done, a setting change part way through a step sequence, and a clear that must keep the quotient flag. A design that shifted in any of these cases, or kept its counter after a setting change, would give a different check value or a different done flag. A restart in the middle of a run checks that exactly two bits of the first word were used before the second word took over.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  localparam int WORD_W   = 16;
  localparam int MAX_BITS = 16;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  // word selects on bus_addr[2:1]
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CHK  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // status bit positions
  localparam int ST_QUO  = 8;
  localparam int ST_DONE = 7;
  localparam int ST_RUN  = 6;
  localparam int ST_STEP = 5;
  localparam int ST_CLR  = 4;
  localparam int ST_DBL  = 3;

  localparam logic [2:0] CODE_C12   = 3'd0;
  localparam logic [2:0] CODE_C16   = 3'd1;
  localparam logic [2:0] CODE_L8    = 3'd2;
  localparam logic [2:0] CODE_L16   = 3'd3;
  localparam logic [2:0] CODE_CCITT = 3'd5;

  function automatic logic [WORD_W-1:0] poly_of(input logic [2:0] code);
    case (code)
      CODE_C12:   return 16'h0F01;
      CODE_C16:   return 16'hA001;
      CODE_CCITT: return 16'h8408;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] bits_of(input logic [2:0] code, input logic dbl);
    logic [CNT_W-1:0] base;
    case (code)
      CODE_C12:                                  base = CNT_W'(6);
      CODE_C16, CODE_L8, CODE_L16, CODE_CCITT:   base = CNT_W'(8);
      default:                                   base = '0;
    endcase
    return dbl ? CNT_W'(base << 1) : base;
  endfunction
endpackage

// File: rtl/bchk_bitcycle.sv
// One serial step of the check engine, purely combinational.
module bchk_bitcycle
  import bchk_pkg::*;
(
  input  logic [WORD_W-1:0] chk_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic [2:0]        code_i,
  output logic [WORD_W-1:0] chk_o,
  output logic [WORD_W-1:0] dat_o,
  output logic              quo_o
);
  logic              is_c12;
  logic [WORD_W-1:0] packed_v, seeded_v, moved_v;
  logic              q;

  assign is_c12 = (code_i == CODE_C12);

  always_comb begin
    // CRC-12 keeps its upper six bits at 13:8; bring them next to 5:0
    packed_v = is_c12 ? ((chk_i & 16'h003F) | ((chk_i >> 2) & 16'h0FC0)) : chk_i;
    q        = packed_v[0] ^ dat_i[0];
    seeded_v = {packed_v[WORD_W-1:1], q};
    if (code_i[1]) begin
      moved_v = code_i[0] ? {seeded_v[0], seeded_v[WORD_W-1:1]}
                          : {8'h00, seeded_v[0], seeded_v[7:1]};
    end else begin
      moved_v = (seeded_v >> 1) ^ (q ? poly_of(code_i) : '0);
    end
    chk_o = is_c12 ? ((moved_v & 16'h003F) | ((moved_v & 16'h0FC0) << 2)) : moved_v;
    dat_o = dat_i >> 1;
    quo_o = q;
  end
endmodule

// File: rtl/bchk_bitcount.sv
// Bit counter increment and end-of-operation compare.
module bchk_bitcount
  import bchk_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       code_i,
  input  logic             dbl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] need;

  assign need   = bits_of(code_i, dbl_i);
  assign cnt_o  = cnt_i + CNT_W'(1);
  assign last_o = (cnt_o >= need);
endmodule

// File: rtl/bchk_readport.sv
// Registered read multiplexer.
module bchk_readport
  import bchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] stat_i,
  input  logic [WORD_W-1:0] chk_i,
  output logic [WORD_W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (sel_i)
        A_STAT:  rdata_o <= stat_i;
        A_CHK:   rdata_o <= chk_i;
        default: rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/blockcheck_unit.sv
module blockcheck_unit
  import bchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_byte,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  logic [WORD_W-1:0] bcc_q, dr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        mode_q;
  logic              quo_q, done_q, sen_q, dbl_q, run_q;

  logic [1:0]        word_sel;
  logic              sr_wr, dr_wr;
  logic [7:0]        sr_val;
  logic [WORD_W-1:0] dr_val;

  // state after the bus write of this clock, before any bit cycle
  logic [WORD_W-1:0] b_bcc, b_dr;
  logic [CNT_W-1:0]  b_cnt;
  logic [2:0]        b_mode;
  logic              b_done, b_sen, b_dbl, b_run, step_req, do_cycle;

  logic [WORD_W-1:0] cyc_bcc, cyc_dr;
  logic              cyc_quo;
  logic [CNT_W-1:0]  cnt_inc;
  logic              cnt_last;
  logic [WORD_W-1:0] stat_word;

  assign word_sel = bus_addr[2:1];
  // an odd-address byte write to status touches only read-only bits: drop it
  assign sr_wr    = bus_wr && (word_sel == A_STAT) && !(bus_byte && bus_addr[0]);
  assign dr_wr    = bus_wr && word_sel[1];
  assign sr_val   = bus_wdata[7:0];
  assign dr_val   = !bus_byte   ? bus_wdata :
                    bus_addr[0] ? {bus_wdata[7:0], dr_q[7:0]} :
                                  {dr_q[15:8], bus_wdata[7:0]};

  always_comb begin
    b_bcc    = bcc_q;
    b_dr     = dr_q;
    b_cnt    = cnt_q;
    b_mode   = mode_q;
    b_done   = done_q;
    b_sen    = sen_q;
    b_dbl    = dbl_q;
    b_run    = run_q;
    step_req = 1'b0;
    if (sr_wr) begin
      if (sr_val[ST_CLR]) begin
        b_bcc  = '0;
        b_cnt  = '0;
        b_done = 1'b1;
      end
      if (sr_val[3:0] != {dbl_q, mode_q}) b_cnt = '0;
      b_sen    = sr_val[ST_RUN];
      b_dbl    = sr_val[ST_DBL];
      b_mode   = sr_val[2:0];
      b_run    = 1'b0;
      step_req = sr_val[ST_STEP] && !sr_val[ST_RUN];
    end else if (dr_wr) begin
      b_dr   = dr_val;
      b_done = 1'b0;
      b_cnt  = '0;
      b_run  = sen_q;
    end
    do_cycle = !b_done && (step_req || (b_run && !sr_wr && !dr_wr));
  end

  bchk_bitcycle u_cycle (
    .chk_i (b_bcc),
    .dat_i (b_dr),
    .code_i(b_mode),
    .chk_o (cyc_bcc),
    .dat_o (cyc_dr),
    .quo_o (cyc_quo)
  );

  bchk_bitcount u_count (
    .cnt_i (b_cnt),
    .code_i(b_mode),
    .dbl_i (b_dbl),
    .cnt_o (cnt_inc),
    .last_o(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bcc_q  <= '0;
      dr_q   <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      quo_q  <= 1'b0;
      done_q <= 1'b1;
      sen_q  <= 1'b0;
      dbl_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      mode_q <= b_mode;
      sen_q  <= b_sen;
      dbl_q  <= b_dbl;
      if (do_cycle) begin
        bcc_q <= cyc_bcc;
        dr_q  <= cyc_dr;
        quo_q <= cyc_quo;
        if (cnt_last) begin
          done_q <= 1'b1;
          cnt_q  <= '0;
          run_q  <= 1'b0;
        end else begin
          done_q <= b_done;
          cnt_q  <= cnt_inc;
          run_q  <= b_run;
        end
      end else begin
        bcc_q  <= b_bcc;
        dr_q   <= b_dr;
        done_q <= b_done;
        cnt_q  <= b_cnt;
        run_q  <= b_run;
      end
    end
  end

  assign stat_word = {7'b0, quo_q, done_q, sen_q, 2'b00, dbl_q, mode_q};

  bchk_readport u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (bus_rd),
    .sel_i  (word_sel),
    .stat_i (stat_word),
    .chk_i  (bcc_q),
    .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/bchk_checker.sv
module bchk_checker
  import bchk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              any_wr,
  input logic              clr_wr,
  input logic              data_wr,
  input logic              data_rd,
  input logic [WORD_W-1:0] rdata,
  input logic [WORD_W-1:0] bcc_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              quo_q,
  input logic              done_q,
  input logic              do_cycle,
  input logic [2:0]        cyc_mode
);
  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> done_q && (bcc_q == '0) && (cnt_q == '0) && (quo_q == $past(quo_q)));

  // R7
  data_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !done_q);

  // R8
  idle_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !any_wr) |=> done_q && $stable(bcc_q) && $stable(quo_q));

  // R6
  c12_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (do_cycle && cyc_mode == CODE_C12) |=> (bcc_q[15:14] == 2'b00) && (bcc_q[7:6] == 2'b00));

  // R2
  data_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> rdata == '0);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(MAX_BITS));
endmodule

bind blockcheck_unit bchk_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .any_wr  (bus_wr),
  .clr_wr  (bus_wr && (bus_addr[2:1] == 2'd0) && !(bus_byte && bus_addr[0]) && bus_wdata[4]),
  .data_wr (bus_wr && bus_addr[2]),
  .data_rd (bus_rd && bus_addr[2]),
  .rdata   (bus_rdata),
  .bcc_q   (bcc_q),
  .cnt_q   (cnt_q),
  .quo_q   (quo_q),
  .done_q  (done_q),
  .do_cycle(do_cycle),
  .cyc_mode(b_mode)
);

// File: tb/sim_blockcheck_unit.sv
`timescale 1ns/1ps
module sim_blockcheck_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] m_bcc = '0, m_dr = '0;
  logic        m_quo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blockcheck_unit u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
                      .bus_byte(bus_byte), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // ---------- reference model, from the requirements ----------
  function automatic logic [15:0] m_poly(input logic [2:0] c);
    case (c)
      3'd0: return 16'h0F01;
      3'd1: return 16'hA001;
      3'd5: return 16'h8408;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int m_bits(input logic [2:0] c, input logic d);
    int b;
    case (c)
      3'd0: b = 6;
      3'd1, 3'd2, 3'd3, 3'd5: b = 8;
      default: b = 0;
    endcase
    return d ? 2 * b : b;
  endfunction

  task automatic m_cycle(input logic [2:0] c);
    logic [15:0] b;
    logic q;
    b = m_bcc;
    if (c == 3'd0) b = (b & 16'h003F) | ((b >> 2) & 16'h0FC0);
    q = b[0] ^ m_dr[0];
    b[0] = q;
    if (c[1]) b = c[0] ? {b[0], b[15:1]} : {8'h00, b[0], b[7:1]};
    else      b = q ? ((b >> 1) ^ m_poly(c)) : (b >> 1);
    if (c == 3'd0) b = (b & 16'h003F) | ((b & 16'h0FC0) << 2);
    m_bcc = b;
    m_dr  = m_dr >> 1;
    m_quo = q;
  endtask

  function automatic logic [15:0] st(input logic q, input logic dn, input logic sn,
                                     input logic db, input logic [2:0] c);
    return {7'b0, q, dn, sn, 2'b00, db, c};
  endfunction

  // ---------- bus helpers (called at a falling edge) ----------
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d, input logic byt);
    bus_addr = a; bus_wdata = d; bus_byte = byt; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int t = 0; t < 40; t++) begin
      bus_read(3'd0, s);
      if (s[7]) break;
    end
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    logic [15:0] v;
    bus_read(3'd0, v); check("R1 status after reset", v, 16'h0080);
    bus_read(3'd2, v); check("R1 check word after reset", v, 16'h0000);
  endtask

  task automatic t_sweep();
    logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
    logic [15:0] v, d;
    for (int k = 0; k < 5; k++) begin
      for (int db = 0; db < 2; db++) begin
        bus_write(3'd0, 16'h0050 | 16'(db << 3) | {13'b0, codes[k]}, 1'b0);
        m_bcc = '0;
        for (int i = 0; i < 4; i++) begin
          d = 16'hC35A ^ 16'(i * 16'h2F61) ^ {13'b0, codes[k]};
          bus_write(3'd4, d, 1'b0);
          m_dr = d;
          for (int b = 0; b < m_bits(codes[k], db[0]); b++) m_cycle(codes[k]);
          wait_done();
          bus_read(3'd2, v); check("R5 R6 R4 check value", v, m_bcc);
          bus_read(3'd0, v); check("R2 R7 status after run", v, st(m_quo, 1'b1, 1'b1, db[0], codes[k]));
        end
      end
    end
  endtask

  task automatic t_step_and_clear();
    logic [15:0] v;
    bus_write(3'd0, 16'h0011, 1'b0); m_bcc = '0;
    bus_write(3'd4, 16'h003C, 1'b0); m_dr = 16'h003C;
    bus_write(3'd0, 16'h0061, 1'b0);
    bus_read(3'd2, v); check("R8 step ignored with run set", v, m_bcc);
    bus_read(3'd0, v); check("R8 still busy", v, st(m_quo, 1'b0, 1'b1, 1'b0, 3'd1));
    for (int k = 1; k <= 8; k++) begin
      bus_write(3'd0, 16'h0021, 1'b0);
      m_cycle(3'd1);
      bus_read(3'd2, v); check("R8 single step value", v, m_bcc);
      bus_read(3'd0, v); check("R8 step done flag", v, st(m_quo, k == 8, 1'b0, 1'b0, 3'd1));
    end
    bus_write(3'd0, 16'h0021, 1'b0);
    bus_read(3'd2, v); check("R8 step after done", v, m_bcc);
    bus_write(3'd0, 16'h0011, 1'b0); m_bcc = '0;
    bus_read(3'd0, v); check("R9 clear keeps quotient", v, st(m_quo, 1'b1, 1'b0, 1'b0, 3'd1));
    bus_read(3'd2, v); check("R9 clear zeroes check", v, 16'h0000);
  endtask

  task automatic t_setup_reset();
    logic [15:0] v;
    bus_write(3'd0, 16'h0015, 1'b0); m_bcc = '0;
    bus_write(3'd4, 16'h005A, 1'b0); m_dr = 16'h005A;
    for (int k = 0; k < 3; k++) begin bus_write(3'd0, 16'h0025, 1'b0); m_cycle(3'd5); end
    bus_write(3'd0, 16'h000D, 1'b0);
    for (int k = 0; k < 15; k++) begin bus_write(3'd0, 16'h002D, 1'b0); m_cycle(3'd5); end
    bus_read(3'd0, v); check("R10 counter restarted", v, st(m_quo, 1'b0, 1'b0, 1'b1, 3'd5));
    bus_write(3'd0, 16'h002D, 1'b0); m_cycle(3'd5);
    bus_read(3'd0, v); check("R10 done at full count", v, st(m_quo, 1'b1, 1'b0, 1'b1, 3'd5));
    bus_read(3'd2, v); check("R10 value", v, m_bcc);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    bus_write(3'd0, 16'h001B, 1'b1); m_bcc = '0;
    bus_write(3'd4, 16'h0034, 1'b1);
    bus_write(3'd5, 16'h0012, 1'b1); m_dr = 16'h1234;
    bus_write(3'd1, 16'h00FF, 1'b1);
    bus_read(3'd0, v); check("R11 odd status byte ignored", v, st(m_quo, 1'b0, 1'b0, 1'b1, 3'd3));
    for (int k = 0; k < 16; k++) begin bus_write(3'd0, 16'h002B, 1'b0); m_cycle(3'd3); end
    bus_read(3'd2, v); check("R11 merged data word", v, m_bcc);
    bus_read(3'd0, v); check("R11 done", v, st(m_quo, 1'b1, 1'b0, 1'b1, 3'd3));
  endtask

  task automatic t_ignored_regs();
    logic [15:0] v;
    bus_write(3'd2, 16'hFFFF, 1'b0);
    bus_read(3'd2, v); check("R3 check word write ignored", v, m_bcc);
    bus_read(3'd4, v); check("R2 data word reads zero", v, 16'h0000);
  endtask

  task automatic t_undefined();
    logic [15:0] v;
    logic q0;
    bus_write(3'd0, 16'h0044, 1'b0);
    bus_write(3'd4, 16'h00FF, 1'b0); m_dr = 16'h00FF;
    q0 = m_quo;
    bus_read(3'd0, v); check("R4 undefined code busy first", v, st(q0, 1'b0, 1'b1, 1'b0, 3'd4));
    m_cycle(3'd4);
    bus_read(3'd0, v); check("R4 undefined code one cycle", v, st(m_quo, 1'b1, 1'b1, 1'b0, 3'd4));
    bus_read(3'd2, v); check("R4 undefined code value", v, m_bcc);
  endtask

  task automatic t_timing();
    logic [15:0] v;
    bus_write(3'd0, 16'h0052, 1'b0); m_bcc = '0;
    bus_write(3'd4, 16'h00A7, 1'b0); m_dr = 16'h00A7;
    repeat (7) @(negedge clk);
    for (int k = 0; k < 7; k++) m_cycle(3'd2);
    bus_read(3'd0, v); check("R7 not done after 7 clocks", v, st(m_quo, 1'b0, 1'b1, 1'b0, 3'd2));
    m_cycle(3'd2);
    bus_read(3'd0, v); check("R7 done after 8 clocks", v, st(m_quo, 1'b1, 1'b1, 1'b0, 3'd2));
  endtask

  task automatic t_restart();
    logic [15:0] v;
    bus_write(3'd0, 16'h0059, 1'b0); m_bcc = '0;
    bus_write(3'd4, 16'hBEEF, 1'b0); m_dr = 16'hBEEF;
    repeat (2) @(negedge clk);
    m_cycle(3'd1); m_cycle(3'd1);
    bus_write(3'd4, 16'h1357, 1'b0); m_dr = 16'h1357;
    for (int k = 0; k < 16; k++) m_cycle(3'd1);
    wait_done();
    bus_read(3'd2, v); check("R12 restart mid run", v, m_bcc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_step_and_clear();
    t_setup_reset();
    t_bytes();
    t_ignored_regs();
    t_undefined();
    t_timing();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule